// File: doc/BRIEF.md
# Double-Buffered Serial Mode-Control Port

This block receives a 6-bit command word over a three-wire write-only serial link made of a data line, a serial clock and an active-low select. The bits enter a shift register while the select is low. The word already in force stays in a separate holding register until the select is released. On that release the whole new word moves into the holding register in one step, so the motor-control logic never sees a word that is only partly written.

The holding register is decoded into control outputs: a sleep request, a spindle brake, a two-bit spindle current-limit code with a one-hot level select, a voice-coil idle control and a step-commutation mode enable. A single-cycle pulse marks each cycle in which a new word takes effect. All three pins are synchronised into the system clock domain, and the serial clock and select edges are found there. The serial clock must therefore run several times slower than the system clock.

Top module: `mode_word_port`

## Requirements
- R1: After reset the held word is all zeros: sleep_req is 1, spin_brake, vcm_idle and step_mode are 0, ilim_code is 00, ilim_sel is 0001 and word_upd is 0.
- R2: The first bit shifted becomes D5 and the last becomes D0. The outputs map as follows: sleep_req = NOT D0, spin_brake = D1, ilim_code = {D2, D3} with D2 as the MSB, vcm_idle = D4, step_mode = D5.
- R3: ilim_sel is one-hot, with bit k set when ilim_code equals k. Code 00 (bit 0) is the highest current limit and code 11 (bit 3) is the lowest.
- R4: A bit is sampled from ser_data only on a rising edge of ser_clk while ser_sel_n is low. Serial clock edges while ser_sel_n is high shift nothing.
- R5: The control outputs do not change while a new word is being shifted in. They change only in the cycle of a word_upd pulse.
- R6: Each rising edge of ser_sel_n gives exactly one word_upd pulse, one system clock wide. The new outputs are valid in that same cycle.
- R7: If more than six bits are shifted before ser_sel_n rises, the word used is made of the last six bits shifted.
- R8: If fewer than six bits are shifted, the word used is made of the six most recently shifted bits, with the remainder taken from earlier writes. A select pulse with no serial clock edges re-applies the word already in the shift register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_data | input | 1 | Serial data in |
| ser_clk | input | 1 | Serial clock; data sampled on its rising edge |
| ser_sel_n | input | 1 | Active-low write select; rising edge commits the word |
| sleep_req | output | 1 | Sleep requested (D0 = 0) |
| spin_brake | output | 1 | Spindle disabled and brake applied (D1) |
| ilim_code | output | 2 | Spindle current-limit code {D2, D3} |
| ilim_sel | output | 4 | One-hot current-limit level, bit 0 highest |
| vcm_idle | output | 1 | Voice-coil disabled, idle mode (D4) |
| step_mode | output | 1 | Test input acts as single-step commutation clock (D5) |
| word_upd | output | 1 | One-cycle pulse when a new word takes effect |

## Verification
The checker watches four rules on every cycle. The shift register does not move while the synchronised select is high. The control outputs stay frozen in every cycle that has no update pulse. The update pulse is never wider than one cycle. The level select always has exactly one bit set. Bit order, field mapping, the handling of words that are too long or too short, and the one-pulse-per-release rule all depend on what was sent on the pins. Only the bench's scenarios show these, by comparing each update pulse against a word modelled from the serial stream.

// File: rtl/mwp_pkg.sv
// Package: shared field positions and the decoded control record for the
// serial mode-control port. Field positions are fixed because downstream
// motor-control logic decodes them.
package mwp_pkg;

    localparam int unsigned FLD_RUN     = 0;  // 1 = normal operation, 0 = sleep
    localparam int unsigned FLD_BRAKE   = 1;  // spindle brake
    localparam int unsigned FLD_ILIM_HI = 2;  // current-limit code MSB
    localparam int unsigned FLD_ILIM_LO = 3;  // current-limit code LSB
    localparam int unsigned FLD_IDLE    = 4;  // voice-coil idle
    localparam int unsigned FLD_STEP    = 5;  // step-commutation mode

    typedef struct packed {
        logic       sleep_req;
        logic       spin_brake;
        logic [1:0] ilim_code;
        logic       vcm_idle;
        logic       step_mode;
    } mwp_ctrl_t;

endpackage

// File: rtl/mwp_sync.sv
// Module: mwp_sync
// Brings a bundle of asynchronous pins into the system clock domain through
// a chain of flops per bit. Assumes each pin is a slow level that holds
// still for several system clocks. RST_VAL is the idle level of each pin.
module mwp_sync #(
    parameter int unsigned            N       = 3,
    parameter int unsigned            STAGES  = 2,
    parameter logic [N-1:0]           RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pins_i,
    output logic [N-1:0] sync_o
);

    genvar b;
    generate
        for (b = 0; b < N; b++) begin : g_bit
            logic [STAGES-1:0] chain_q;

            // Purpose: shift the pin level through the synchroniser chain.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    chain_q <= {STAGES{RST_VAL[b]}};
                end else begin
                    chain_q <= {chain_q[STAGES-2:0], pins_i[b]};
                end
            end

            assign sync_o[b] = chain_q[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/mwp_shifter.sv
// Module: mwp_shifter
// Finds serial-clock and select edges in the system domain. It shifts data
// in on serial-clock rising edges while the select is low, and raises a
// one-cycle commit strobe on the select rising edge. Assumes the inputs
// are already synchronised. The newest bit enters at bit 0, so after six
// shifts the first bit sent sits in the top bit.
module mwp_shifter #(
    parameter int unsigned W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         s_clk,
    input  logic         s_sel_n,
    input  logic         s_dat,
    output logic [W-1:0] shreg_o,
    output logic         commit_o
);

    logic         clk_prev_q;
    logic         sel_prev_q;
    logic [W-1:0] shreg_q;
    logic         clk_rise;
    logic         do_shift;

    assign clk_rise = s_clk & ~clk_prev_q;
    assign do_shift = clk_rise & ~s_sel_n;
    assign commit_o = s_sel_n & ~sel_prev_q;
    assign shreg_o  = shreg_q;

    // Purpose: remember last synchronised levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clk_prev_q <= 1'b0;
            sel_prev_q <= 1'b1;
        end else begin
            clk_prev_q <= s_clk;
            sel_prev_q <= s_sel_n;
        end
    end

    // Purpose: shift one data bit in per qualified serial-clock edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg_q <= '0;
        end else if (do_shift) begin
            shreg_q <= {shreg_q[W-2:0], s_dat};
        end
    end

endmodule

// File: rtl/mwp_hold.sv
// Module: mwp_hold
// Holding register for the active word plus field decode. It loads only on
// the commit strobe and raises the update pulse in the same cycle that
// the new word appears. Reset value is all zeros, which means sleep.
module mwp_hold #(
    parameter int unsigned W      = 6,
    parameter int unsigned LEVELS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit_i,
    input  logic [W-1:0]      word_i,
    output mwp_pkg::mwp_ctrl_t ctrl_o,
    output logic [LEVELS-1:0] ilim_sel_o,
    output logic              upd_o
);
    import mwp_pkg::*;

    localparam int unsigned CODE_W = $clog2(LEVELS);

    logic [W-1:0]      held_q;
    logic              upd_q;
    logic [CODE_W-1:0] code;

    // Purpose: capture the shifted word when the select is released.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_q <= '0;
            upd_q  <= 1'b0;
        end else begin
            upd_q <= commit_i;
            if (commit_i) begin
                held_q <= word_i;
            end
        end
    end

    assign code = {held_q[FLD_ILIM_HI], held_q[FLD_ILIM_LO]};

    // Purpose: map held bits onto named controls.
    always_comb begin
        ctrl_o.sleep_req  = ~held_q[FLD_RUN];
        ctrl_o.spin_brake = held_q[FLD_BRAKE];
        ctrl_o.ilim_code  = code;
        ctrl_o.vcm_idle   = held_q[FLD_IDLE];
        ctrl_o.step_mode  = held_q[FLD_STEP];
    end

    genvar k;
    generate
        for (k = 0; k < LEVELS; k++) begin : g_lvl
            assign ilim_sel_o[k] = (code == CODE_W'(k));
        end
    endgenerate

    assign upd_o = upd_q;

endmodule

// File: rtl/mode_word_port.sv
// Module: mode_word_port (top)
// Write-only three-wire serial port for a 6-bit mode word, double
// buffered. Pins are synchronised, edges are detected in the system
// domain, and the active word is replaced atomically on select release.
// Assumes the serial clock phases each last at least three system clocks.
module mode_word_port #(
    parameter int unsigned W        = 6,
    parameter int unsigned SYNC_STG = 2,
    parameter int unsigned LEVELS   = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ser_data,
    input  logic       ser_clk,
    input  logic       ser_sel_n,
    output logic       sleep_req,
    output logic       spin_brake,
    output logic [1:0] ilim_code,
    output logic [3:0] ilim_sel,
    output logic       vcm_idle,
    output logic       step_mode,
    output logic       word_upd
);
    import mwp_pkg::*;

    logic [2:0]   pins_sync;
    logic         sync_dat;
    logic         sync_clk;
    logic         sync_sel_n;
    logic [W-1:0] shreg;
    logic         commit;
    mwp_ctrl_t    ctrl;

    mwp_sync #(
        .N      (3),
        .STAGES (SYNC_STG),
        .RST_VAL(3'b100)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .pins_i({ser_sel_n, ser_clk, ser_data}),
        .sync_o(pins_sync)
    );

    assign sync_dat   = pins_sync[0];
    assign sync_clk   = pins_sync[1];
    assign sync_sel_n = pins_sync[2];

    mwp_shifter #(.W(W)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .s_clk   (sync_clk),
        .s_sel_n (sync_sel_n),
        .s_dat   (sync_dat),
        .shreg_o (shreg),
        .commit_o(commit)
    );

    mwp_hold #(.W(W), .LEVELS(LEVELS)) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .commit_i  (commit),
        .word_i    (shreg),
        .ctrl_o    (ctrl),
        .ilim_sel_o(ilim_sel),
        .upd_o     (word_upd)
    );

    assign sleep_req  = ctrl.sleep_req;
    assign spin_brake = ctrl.spin_brake;
    assign ilim_code  = ctrl.ilim_code;
    assign vcm_idle   = ctrl.vcm_idle;
    assign step_mode  = ctrl.step_mode;

endmodule

// File: rtl/mwp_checker.sv
// Module: mwp_checker
// Cycle-by-cycle rules for mode_word_port, attached with bind.
module mwp_checker #(
    parameter int unsigned W = 6
) (
    input logic         clk,
    input logic         rst_n,
    input logic         sync_sel_n,
    input logic [W-1:0] shreg,
    input logic         word_upd,
    input logic [5:0]   ctrl_bus,
    input logic [3:0]   ilim_sel
);

    // R4: no shifting while the synchronised select is high
    assert_shift_gated_R4: assert property (@(posedge clk) disable iff (!rst_n)
        sync_sel_n |=> $stable(shreg));

    // R5: controls change only with an update pulse
    assert_ctrl_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !word_upd |-> $stable(ctrl_bus));

    // R6: update pulse is one cycle wide
    assert_upd_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        word_upd |=> !word_upd);

    // R3: exactly one current-limit level selected
    assert_ilim_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(ilim_sel) == 1);

endmodule

bind mode_word_port mwp_checker #(.W(W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sync_sel_n(sync_sel_n),
    .shreg     (shreg),
    .word_upd  (word_upd),
    .ctrl_bus  ({sleep_req, spin_brake, ilim_code, vcm_idle, step_mode}),
    .ilim_sel  (ilim_sel)
);

// File: tb/mode_word_port_test.sv
// Bench: the driver models the shift register from the serial stream and
// queues the expected word on each select release. The monitor pops and
// compares on every update pulse.
module mode_word_port_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ser_data = 1'b0;
    logic       ser_clk = 1'b0;
    logic       ser_sel_n = 1'b1;
    logic       sleep_req, spin_brake, vcm_idle, step_mode, word_upd;
    logic [1:0] ilim_code;
    logic [3:0] ilim_sel;

    int checks = 0;
    int errors = 0;
    logic [5:0] mdl = 6'b0;       // bench model of the shift register
    logic [5:0] cur = 6'b0;       // last word expected in force
    logic [5:0] expq[$];
    int pulses = 0;

    always #2 clk = ~clk;         // 250 MHz

    mode_word_port uut (
        .clk(clk), .rst_n(rst_n), .ser_data(ser_data), .ser_clk(ser_clk),
        .ser_sel_n(ser_sel_n), .sleep_req(sleep_req), .spin_brake(spin_brake),
        .ilim_code(ilim_code), .ilim_sel(ilim_sel), .vcm_idle(vcm_idle),
        .step_mode(step_mode), .word_upd(word_upd)
    );

    // Compare all outputs against word w per R2 and R3.
    task automatic cmp_word(input logic [5:0] w, input string tag);
        logic [11:0] act, exp;
        act = {sleep_req, spin_brake, ilim_code, vcm_idle, step_mode, ilim_sel};
        exp = {~w[0], w[1], {w[2], w[3]}, w[4], w[5], 4'b0001 << {w[2], w[3]}};
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: outputs act=%b exp=%b", tag, act, exp);
        end
    endtask

    // Monitor: pops an expected word on each update pulse (R6).
    always @(negedge clk) begin
        if (rst_n && word_upd) begin
            pulses++;
            if (expq.size() == 0) begin
                checks++; errors++;
                $display("FAIL R6: unexpected word_upd act=1 exp=0");
            end else begin
                cmp_word(expq.pop_front(), "R2/R7/R8 word");
            end
        end
    end

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Driver: send n bits of bits (MSB first) inside one select window.
    task automatic write_bits(input logic [15:0] bits, input int n, input logic midcheck);
        ser_sel_n = 1'b0;
        wait_clk(4);
        for (int i = n - 1; i >= 0; i--) begin
            ser_data = bits[i];
            wait_clk(4);
            ser_clk = 1'b1;
            mdl = {mdl[4:0], bits[i]};
            wait_clk(4);
            ser_clk = 1'b0;
            if (midcheck && i == n / 2) cmp_word(cur, "R5 mid-shift");
        end
        wait_clk(4);
        ser_sel_n = 1'b1;
        expq.push_back(mdl);
        cur = mdl;
        wait_clk(10);
    endtask

    // Toggle the serial clock with the select high: must shift nothing (R4).
    task automatic idle_clocks(input int n);
        for (int i = 0; i < n; i++) begin
            ser_data = ~ser_data;
            wait_clk(4);
            ser_clk = 1'b1;
            wait_clk(4);
            ser_clk = 1'b0;
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: run hung act=timeout exp=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        int p0;
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(3);
        // R1: reset state
        cmp_word(6'b000000, "R1 reset");
        checks++;
        if (word_upd !== 1'b0) begin
            errors++; $display("FAIL R1: word_upd act=%b exp=0", word_upd);
        end

        // R2: each field alone, first bit sent = D5
        write_bits(16'b000001, 6, 1'b0);   // run
        write_bits(16'b000010, 6, 1'b1);   // brake only, sleep
        write_bits(16'b010001, 6, 1'b1);   // idle + run
        write_bits(16'b100001, 6, 1'b1);   // step + run
        // R3: all current-limit codes, D2 MSB
        write_bits(16'b000101, 6, 1'b0);   // code 10
        write_bits(16'b001001, 6, 1'b0);   // code 01
        write_bits(16'b001101, 6, 1'b1);   // code 11
        write_bits(16'b000001, 6, 1'b0);   // code 00
        write_bits(16'b111111, 6, 1'b1);

        // R4: serial clocks with select high are ignored, then empty
        // select pulse re-applies the unchanged shift register (R8)
        idle_clocks(6);
        cmp_word(cur, "R4 idle clocks");
        write_bits(16'b0, 0, 1'b0);

        // R7: nine bits, last six used
        write_bits(16'b101_010011, 9, 1'b1);
        // R8: three bits, earlier bits kept
        write_bits(16'b110, 3, 1'b1);

        // R6: exactly one pulse per release
        p0 = pulses;
        write_bits(16'b011000, 6, 1'b0);
        checks++;
        if (pulses - p0 != 1) begin
            errors++; $display("FAIL R6: pulses act=%0d exp=1", pulses - p0);
        end
        // R5: outputs stable afterwards
        wait_clk(20);
        cmp_word(cur, "R5 hold");
        checks++;
        if (expq.size() != 0) begin
            errors++; $display("FAIL R6: missing pulses act=%0d exp=0 pending", expq.size());
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule